// File: doc/BRIEF.md
# Serial Receiver with Per-Character Line Status

This block turns an asynchronous serial line into bytes a host can read. It watches the line with a 16x oversampling tick, finds each start bit and samples every later bit once at its midpoint. It then stores the character, and each character carries its own error tags. The character goes either into a single holding register or, when queueing is switched on, into a small receive queue. The host reads through a two-address port: one address returns the oldest unread character and the other returns a line status byte.

The tags for break, framing and parity travel through the queue with the character they belong to. The status byte always describes the character now at the head. When that character is read out, the status switches to the tags of the next one. A line held low for a whole character time stores exactly one null character, whatever the length of the break. In multidrop mode the ninth bit is passed to the host as an address/data marker instead of being checked as parity.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset, `data_ready` is 0 and a status read (`rd_addr`=1) returns 0x00.
- R2: A falling edge followed by a low line at the 8th oversample tick starts a character. Data bits are taken least significant first, one sample per bit at mid-bit. A low pulse that has ended before that 8th tick is ignored.
- R3: `data_ready` (also status bit 0) is 1 while unread data exists. It goes to 0 once the last stored character has been read (`rd_addr`=0).
- R4: With parity enabled and multidrop off, one parity bit follows the data. Status bit 2 is 1 for a head character whose data ones plus parity bit give an odd total under even parity (`par_odd`=0), or an even total under odd parity (`par_odd`=1). With parity and multidrop both off, no ninth bit is expected and bit 2 stays 0.
- R5: In multidrop mode a ninth bit is always received, and status bit 2 shows its value for the head character (1 = address byte, 0 = data byte).
- R6: Status bit 3 is 1 when the head character was received with a stop bit sampled as 0.
- R7: When every sampled bit of a frame, stop bit included, is 0, the block stores one character 0x00 with status bits 4 and 3 set and bit 2 clear. It stores nothing further until the line has been seen high.
- R8: Tags stay with their own character. After a receive-buffer read, status bits 4..2 show the tags of the new head character.
- R9: A status read clears status bits 4..2 for the current head character. They stay clear until the head character changes.
- R10: With queueing off, a character that completes while the holding register is unread replaces it and sets status bit 1. Any receive-buffer read clears bit 1.
- R11: With queueing on, a character that completes while the queue holds FIFO_DEPTH entries is discarded and sets status bit 1. Bit 1 clears when a read empties the queue.
- R12: Status bits 7..5 always read 0. A receive-buffer read with no data returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_en | input | 1 | 1 selects the receive queue, 0 the single holding register |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| multidrop | input | 1 | Ninth bit reported as address marker |
| rd_en | input | 1 | Host read strobe; side effects apply at the clock edge |
| rd_addr | input | 1 | 0 receive buffer (pops), 1 line status |
| rd_data | output | 8 | Combinational read data for the selected address |
| data_ready | output | 1 | Unread data present |

## Verification
A character is stored one clock after the stop bit's mid-bit sample. That sample comes two synchronizer stages and eight oversample ticks into the stop bit, so the bench waits two idle bit times after each frame before it reads. Read data is combinational: the bench raises the strobe at a falling clock edge and samples shortly after. The pop or the flag clear that the read causes takes effect at the next rising edge, so the next read, one cycle later, sees the new head. A bench reference model of the queue, holding register and overrun flag is updated at those same points.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic       bi;
      logic       fe;
      logic       pe;
      logic [7:0] data;
   } rx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_NINTH,
      ST_STOP,
      ST_BRK
   } rx_state_e;

   localparam int STAT_DR = 0;
   localparam int STAT_OE = 1;
   localparam int STAT_PE = 2;
   localparam int STAT_FE = 3;
   localparam int STAT_BI = 4;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OSR       = 16,
   localparam int CW       = $clog2(OSR),
   localparam int IW       = $clog2(DATA_BITS)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rxd,
   input  logic     baud_tick,
   input  logic     par_en,
   input  logic     par_odd,
   input  logic     multidrop,
   output logic     char_valid,
   output rx_char_t char_out
);

   localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

   if (DATA_BITS < 5 || DATA_BITS > 8) begin : g_bad_width
      $error("uart_rx_sampler: DATA_BITS must be 5..8");
   end
   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("uart_rx_sampler: OSR must be a power of two >= 4");
   end

   logic [2:0]           sync_q;
   logic                 rx_s, rx_prev;
   rx_state_e            state_q;
   logic [CW-1:0]        os_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] shreg_q;
   logic                 ninth_q;
   logic                 all_low_q;
   logic                 has9;
   logic                 at_mid, at_bit;
   rx_char_t             nxt_char;
   rx_char_t             char_q;
   logic                 valid_q;

   assign rx_s    = sync_q[1];
   assign rx_prev = sync_q[2];
   assign has9    = par_en | multidrop;
   assign at_mid  = baud_tick && (os_q == MID_CNT);
   assign at_bit  = baud_tick && (os_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[1:0], rxd};
   end

   always_comb begin
      nxt_char = '0;
      nxt_char.data[DATA_BITS-1:0] = shreg_q;
      nxt_char.fe = ~rx_s;
      nxt_char.bi = all_low_q & ~rx_s;
      if (multidrop) nxt_char.pe = ninth_q;
      else           nxt_char.pe = par_en & ~nxt_char.bi & (^shreg_q ^ ninth_q ^ par_odd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         os_q      <= '0;
         idx_q     <= '0;
         shreg_q   <= '0;
         ninth_q   <= 1'b0;
         all_low_q <= 1'b0;
         char_q    <= '0;
         valid_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (rx_prev && !rx_s) begin
                  state_q <= ST_START;
                  os_q    <= '0;
               end
            end
            ST_START: begin
               if (at_mid) begin
                  os_q <= '0;
                  if (!rx_s) begin
                     state_q   <= ST_DATA;
                     idx_q     <= '0;
                     all_low_q <= 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else if (baud_tick) begin
                  os_q <= os_q + 1'b1;
               end
            end
            ST_DATA: begin
               if (at_bit) begin
                  os_q      <= '0;
                  shreg_q   <= {rx_s, shreg_q[DATA_BITS-1:1]};
                  all_low_q <= all_low_q & ~rx_s;
                  if (idx_q == IW'(DATA_BITS - 1)) state_q <= has9 ? ST_NINTH : ST_STOP;
                  else                             idx_q   <= idx_q + 1'b1;
               end else if (baud_tick) begin
                  os_q <= os_q + 1'b1;
               end
            end
            ST_NINTH: begin
               if (at_bit) begin
                  os_q      <= '0;
                  ninth_q   <= rx_s;
                  all_low_q <= all_low_q & ~rx_s;
                  state_q   <= ST_STOP;
               end else if (baud_tick) begin
                  os_q <= os_q + 1'b1;
               end
            end
            ST_STOP: begin
               if (at_bit) begin
                  os_q    <= '0;
                  valid_q <= 1'b1;
                  char_q  <= nxt_char;
                  state_q <= nxt_char.bi ? ST_BRK : ST_IDLE;
               end else if (baud_tick) begin
                  os_q <= os_q + 1'b1;
               end
            end
            ST_BRK: begin
               if (rx_s) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign char_valid = valid_q;
   assign char_out   = char_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R2
   AST_BRK_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && char_q.bi) |-> (char_q.data == 8'h00 && char_q.fe && !char_q.pe)); // R7
   AST_BRK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BRK && !rx_s) |=> !valid_q); // R7

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int WIDTH = 11,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic [LW-1:0]    level
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [LW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == LW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign rdata   = mem[rd_q];
   assign level   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop); // R11
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R3
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LW'(DEPTH)); // R11

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OSR        = 16,
   parameter int FIFO_DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   input  logic       baud_tick,
   input  logic       fifo_en,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       multidrop,
   input  logic       rd_en,
   input  logic       rd_addr,
   output logic [7:0] rd_data,
   output logic       data_ready
);

   localparam int  FD       = (FIFO_DEPTH > 0) ? FIFO_DEPTH : 2;
   localparam int  LW       = $clog2(FD) + 1;
   localparam int  CHW      = $bits(rx_char_t);
   localparam bit  HAS_FIFO = (FIFO_DEPTH > 0);

   logic          ev_valid;
   rx_char_t      ev_char;
   logic          fifo_mode;
   logic          rbr_rd, lsr_rd;
   logic          fifo_push, fifo_pop;
   rx_char_t      f_head;
   logic          f_empty, f_full;
   logic [LW-1:0] f_level;
   rx_char_t      hold_q;
   logic          hold_v;
   rx_char_t      head;
   logic          head_valid;
   logic          head_chg;
   logic          clr_q;
   logic          ovr_q, ovr_set, ovr_clr;
   logic [7:0]    lsr_val, rbr_val;

   uart_rx_sampler #(
      .DATA_BITS(DATA_BITS),
      .OSR      (OSR)
   ) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .baud_tick (baud_tick),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .multidrop (multidrop),
      .char_valid(ev_valid),
      .char_out  (ev_char)
   );

   assign fifo_mode = fifo_en && HAS_FIFO;
   assign rbr_rd    = rd_en && !rd_addr;
   assign lsr_rd    = rd_en && rd_addr;
   assign fifo_pop  = fifo_mode && rbr_rd && !f_empty;
   assign fifo_push = fifo_mode && ev_valid && (!f_full || fifo_pop);

   if (HAS_FIFO) begin : g_fifo
      uart_rx_fifo #(
         .WIDTH(CHW),
         .DEPTH(FD)
      ) u_fifo (
         .clk  (clk),
         .rst_n(rst_n),
         .push (fifo_push),
         .pop  (fifo_pop),
         .wdata(ev_char),
         .rdata(f_head),
         .empty(f_empty),
         .full (f_full),
         .level(f_level)
      );
   end else begin : g_nofifo
      assign f_head  = '0;
      assign f_empty = 1'b1;
      assign f_full  = 1'b0;
      assign f_level = '0;
   end

   // single holding register used when queueing is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         hold_v <= 1'b0;
      end else if (!fifo_mode) begin
         if (ev_valid) begin
            hold_q <= ev_char;
            hold_v <= 1'b1;
         end else if (rbr_rd) begin
            hold_v <= 1'b0;
         end
      end
   end

   assign head       = fifo_mode ? f_head : hold_q;
   assign head_valid = fifo_mode ? !f_empty : hold_v;
   assign head_chg   = fifo_pop || (fifo_push && f_empty) ||
                       (!fifo_mode && (ev_valid || (rbr_rd && hold_v)));

   // status-read clear applies to the current head only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        clr_q <= 1'b0;
      else if (head_chg) clr_q <= 1'b0;
      else if (lsr_rd)   clr_q <= 1'b1;
   end

   assign ovr_set = ev_valid && (fifo_mode ? (f_full && !fifo_pop) : (hold_v && !rbr_rd));
   assign ovr_clr = fifo_mode ? (fifo_pop && (f_level == LW'(1)) && !fifo_push) : rbr_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
   end

   always_comb begin
      lsr_val          = '0;
      lsr_val[STAT_DR] = head_valid;
      lsr_val[STAT_OE] = ovr_q;
      lsr_val[STAT_PE] = head_valid && head.pe && !clr_q;
      lsr_val[STAT_FE] = head_valid && head.fe && !clr_q;
      lsr_val[STAT_BI] = head_valid && head.bi && !clr_q;
      rbr_val          = head_valid ? head.data : 8'h00;
   end

   assign rd_data    = rd_addr ? lsr_val : rbr_val;
   assign data_ready = head_valid;

   AST_DR_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> data_ready); // R3
   AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !head_chg) |=> (lsr_val[STAT_BI:STAT_PE] == 3'b000)); // R9
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(ev_valid)); // R10
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr |-> (rd_data[7:5] == 3'b000)); // R12

endmodule

// File: tb/tb_uart_rx_lsr.sv
module tb_uart_rx_lsr;

   localparam int BIT_CLK = 32;
   localparam int DEPTH   = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       baud_tick = 1'b0;
   logic       fifo_en = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       multidrop = 1'b0;
   logic       rd_en = 1'b0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       data_ready;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // reference model
   bit [10:0] m_q [DEPTH];
   int        m_cnt = 0;
   bit [10:0] m_hold = '0;
   bit        m_hv = 0, m_ovr = 0, m_clr = 0;

   uart_rx_lsr dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
      .fifo_en(fifo_en), .par_en(par_en), .par_odd(par_odd), .multidrop(multidrop),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .data_ready(data_ready)
   );

   always #10 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         baud_tick = ~baud_tick;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit m_valid();
      return fifo_en ? (m_cnt > 0) : m_hv;
   endfunction

   function automatic bit [10:0] m_head();
      return fifo_en ? m_q[0] : m_hold;
   endfunction

   function automatic int exp_lsr();
      bit v; bit [10:0] h;
      v = m_valid();
      h = m_head();
      return 32'({3'b000, v & h[10] & ~m_clr, v & h[9] & ~m_clr, v & h[8] & ~m_clr, m_ovr, v});
   endfunction

   task automatic m_push(input bit [10:0] e);
      if (fifo_en) begin
         if (m_cnt == DEPTH) m_ovr = 1;
         else begin
            if (m_cnt == 0) m_clr = 0;
            m_q[m_cnt] = e;
            m_cnt++;
         end
      end else begin
         if (m_hv) m_ovr = 1;
         m_hold = e;
         m_hv = 1;
         m_clr = 0;
      end
   endtask

   task automatic m_pop();
      if (fifo_en) begin
         if (m_cnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
            m_cnt--;
            m_clr = 0;
            if (m_cnt == 0) m_ovr = 0;
         end
      end else begin
         if (m_hv) m_clr = 0;
         m_hv = 0;
         m_ovr = 0;
      end
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic tx_char(input bit [7:0] d, input bit ninth, input bit stop);
      bit has9, bi, pe;
      has9 = par_en | multidrop;
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      if (has9) drive_bit(ninth);
      drive_bit(stop);
      drive_bit(1'b1);
      drive_bit(1'b1);
      bi = (d == 8'h00) && (!has9 || !ninth) && !stop;
      if (multidrop) pe = ninth;
      else           pe = par_en && !bi && (^d ^ ninth ^ par_odd);
      m_push({bi, !stop, pe, d});
   endtask

   task automatic tx_break(input int nbits);
      @(negedge clk);
      rxd = 1'b0;
      repeat (nbits * BIT_CLK) @(negedge clk);
      drive_bit(1'b1);
      drive_bit(1'b1);
      m_push({1'b1, 1'b1, 1'b0, 8'h00});
   endtask

   task automatic rd_lsr(input string req);
      int e;
      e = exp_lsr();
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 1'b1;
      #2;
      check(req, 32'(rd_data), e);
      check({req, " data_ready"}, 32'(data_ready), e & 1);
      @(negedge clk);
      rd_en = 1'b0;
      m_clr = 1;
   endtask

   task automatic rd_rbr(input string req);
      int e;
      e = m_valid() ? 32'(m_head() & 11'h0FF) : 0;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 1'b0;
      #2;
      check(req, 32'(rd_data), e);
      @(negedge clk);
      rd_en = 1'b0;
      m_pop();
   endtask

   task automatic set_cfg(input bit f, input bit p, input bit o, input bit m);
      @(negedge clk);
      fifo_en = f; par_en = p; par_odd = o; multidrop = m;
   endtask

   task automatic drain(input string req);
      rd_rbr(req);
      while (m_valid()) rd_rbr(req);
      rd_lsr(req);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      rd_lsr("R1 reset status");

      // R2 R3 R12 plain byte with queueing
      set_cfg(1, 0, 0, 0);
      tx_char(8'hA5, 0, 1);
      rd_lsr("R3 ready after store");
      rd_rbr("R2 byte lsb first");
      rd_lsr("R3 ready cleared");
      rd_rbr("R12 empty read zero");

      // R2 short low pulse is not a start bit
      @(negedge clk);
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT_CLK) @(negedge clk);
      rd_lsr("R2 glitch ignored");

      // R4 even parity, tags follow (R8), status clear (R9)
      set_cfg(1, 1, 0, 0);
      tx_char(8'h07, 0, 1);
      tx_char(8'h07, 1, 1);
      rd_lsr("R4 even parity error");
      rd_lsr("R9 flags cleared by status read");
      rd_rbr("R8 first char data");
      rd_lsr("R8 next head clean");
      rd_rbr("R8 second char data");
      set_cfg(1, 1, 1, 0);
      tx_char(8'h03, 0, 1);
      rd_lsr("R4 odd parity error");
      rd_rbr("R4 odd parity data");

      // R6 framing error travels with its character
      set_cfg(1, 0, 0, 0);
      tx_char(8'h55, 0, 0);
      tx_char(8'h12, 0, 1);
      rd_lsr("R6 framing flag");
      rd_rbr("R6 framing data");
      rd_lsr("R8 head after framing");
      rd_rbr("R8 clean data");

      // R7 long break stores one null
      tx_break(30);
      rd_lsr("R7 break status");
      rd_rbr("R7 null char");
      rd_lsr("R7 only one entry");
      tx_char(8'h3C, 0, 1);
      rd_rbr("R7 receive after break");

      // R5 multidrop marker
      set_cfg(1, 0, 0, 1);
      tx_char(8'h42, 1, 1);
      rd_lsr("R5 address byte");
      rd_rbr("R5 address data");
      tx_char(8'h43, 0, 1);
      rd_lsr("R5 data byte");
      rd_rbr("R5 data value");

      // R11 queue overrun
      set_cfg(1, 0, 0, 0);
      for (int i = 0; i < DEPTH + 1; i++) tx_char(8'(i + 1), 0, 1);
      rd_lsr("R11 overrun set");
      for (int i = 0; i < DEPTH; i++) rd_rbr("R11 stored order");
      rd_lsr("R11 overrun cleared when drained");

      // R10 holding register overrun
      set_cfg(0, 0, 0, 0);
      tx_char(8'h11, 0, 1);
      tx_char(8'h22, 0, 1);
      rd_lsr("R10 overrun set");
      rd_rbr("R10 newest kept");
      rd_lsr("R10 overrun cleared");

      // R8 random mix
      for (int blk = 0; blk < 6; blk++) begin
         drain("R8 random drain");
         set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         for (int i = 0; i < 12; i++) begin
            bit [7:0] d;
            d = 8'($urandom);
            if (($urandom % 6) == 0) d = 8'h00;
            tx_char(d, 1'($urandom), ($urandom % 6) != 0);
            case ($urandom % 4)
               0: rd_lsr("R8 random status");
               1: rd_rbr("R8 random data");
               2: begin
                  rd_lsr("R8 random status");
                  rd_rbr("R8 random data");
               end
               default: ;
            endcase
         end
      end
      drain("R3 final drain");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule